// File: doc/BRIEF.md
# EDO Page-Mode DRAM Access Sequencer

This block sits on the controller side of a 36-bit hyper page (EDO) DRAM module. A host hands it one word request at a time over a valid/ready handshake. Each request carries a word address, a write flag and, for writes, a 36-bit data word. The sequencer splits the address into a row half and a column half and sends them in turn over a shared address bus. It drives the row strobe pair, four column strobe lanes and the write enable. For reads it captures the returned word and presents it with a one-cycle valid pulse.

After an access the sequencer keeps the row open. A later request to the same row then costs only a column cycle. A request to a different row first closes the row and waits out a full precharge. The read word is captured on the clock edge that raises the column strobes. This edge can arrive because the extended data hold of the EDO part keeps the word on the bus after the strobe rises. All DRAM timing minimums are given in nanoseconds and converted to clock counts for the configured clock period. A row held open too long is closed by the sequencer on its own, well before the module's row-active limit.

The data bus appears as separate output, output-enable and input ports. The tristate buffer belongs outside the block.

Top module: `edo_page_seq`

## Requirements
- R1: The row half (`req_addr` upper ROW_W bits) is on `dram_addr` when the row strobes fall. The column half (lower COL_W bits) is on `dram_addr` when the column strobes fall.
- R2: A read returns the word stored at the requested address on `rd_data`. `rd_valid` pulses for one cycle, on the cycle after the edge that raises the column strobes.
- R3: For a write, `dram_we_n` is low and `dram_dq_oe` is high with the data on `dram_dq_out` before the column strobes fall. For a read, `dram_we_n` is high and `dram_dq_oe` is low. In both cases `dram_we_n` is stable while the column strobes are low.
- R4: The four column lanes (lane i carries data bits 9i+8..9i: 8 data bits and 1 parity bit) switch together. The two row strobes switch together. No column strobe is low while the row strobes are high.
- R5: The row strobes stay high for at least the precharge time (30 ns, 3 cycles at 10 ns) before each fall.
- R6: At least the row-to-column delay (18 ns, 2 cycles) passes from a row strobe fall to the next column strobe fall.
- R7: The column strobes stay low for at least the larger of the strobe width and the read access time (13 ns, 2 cycles). Between two column accesses they stay high for at least the page precharge time (8 ns, 1 cycle).
- R8: A request whose row equals the open row is served with a column-only cycle and the row strobes do not toggle. A request to another row closes the row and opens the new one.
- R9: The row strobes are never low for more than the row-active limit in cycles. An open row with no traffic is closed by the sequencer before that limit.
- R10: Out of reset, the row and column strobes and the write enable are high, the output enable and `rd_valid` are low, and `req_ready` is high.
- R11: Each handshake accepts exactly one request, and `req_ready` is low in the cycle after an accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Word address, row in upper bits |
| req_wdata | input | LANES*LANE_W | Write data word |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | LANES*LANE_W | Read data word |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_ras_n | output | 2 | Row strobes, active low |
| dram_cas_n | output | LANES | Column strobe per lane, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | LANES*LANE_W | Data driven to the module |
| dram_dq_oe | output | 1 | Enable for the data drivers |
| dram_dq_in | input | LANES*LANE_W | Data returned by the module |

## Verification
The embedded properties take for granted that `req_valid` holds its fields steady only for the accepting cycle, and that the reset lasts at least one edge. They also assume the returned data is only ever sampled, so they constrain no value on `dram_dq_in`. The bench keeps to this. It drives requests one at a time at the falling clock edge, waits for `req_ready`, and drops `req_valid` right after the accept. A behavioural module model built from the pin sequence alone supplies `dram_dq_in`. It drives the stored word from the first falling edge after the column strobe fall and keeps it until both strobes are high.

// File: rtl/edo_seq_pkg.sv
package edo_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ROWSET,
    S_RCD,
    S_COLSET,
    S_CASLOW,
    S_OPEN,
    S_PRECH
  } seq_state_t;

  // Whole clock cycles covering a nanosecond minimum, never below one.
  function automatic int unsigned ns_to_cyc(input int unsigned ns,
                                            input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/edo_delay_cnt.sv
module edo_delay_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         done
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/edo_row_tracker.sv
module edo_row_tracker #(
  parameter int          ROW_W        = 10,
  parameter int unsigned TRAS_MAX_CYC = 10000,
  parameter int unsigned CLOSE_AT     = 9990,
  parameter int          AGE_W        = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ras_low,
  input  logic             open_set,
  input  logic             close_set,
  input  logic [ROW_W-1:0] open_row,
  input  logic [ROW_W-1:0] req_row,
  output logic             hit,
  output logic             expired,
  output logic [AGE_W-1:0] age
);
  logic             open_q;
  logic [ROW_W-1:0] row_q;
  logic [AGE_W-1:0] age_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      row_q  <= '0;
    end else if (open_set) begin
      open_q <= 1'b1;
      row_q  <= open_row;
    end else if (close_set) begin
      open_q <= 1'b0;
    end
  end

  // Cycles the row strobes have been low, saturating.
  always_ff @(posedge clk) begin
    if (rst || !ras_low)  age_q <= '0;
    else if (age_q != '1) age_q <= age_q + 1'b1;
  end

  assign expired = (age_q >= AGE_W'(CLOSE_AT));
  assign hit     = open_q && (req_row == row_q) && !expired;
  assign age     = age_q;

  assert_ras_limit_R9: assert property (@(posedge clk) disable iff (rst)
    age_q <= AGE_W'(TRAS_MAX_CYC));

  assert_open_implies_low_R8: assert property (@(posedge clk) disable iff (rst)
    (open_q && !open_set) |-> ras_low);
endmodule

// File: rtl/edo_lane_bank.sv
module edo_lane_bank #(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cas_fall,
  input  logic             cas_rise,
  input  logic             wr_load,
  input  logic [DW-1:0]    wr_word,
  input  logic             cap,
  input  logic [DW-1:0]    dq_in,
  output logic [LANES-1:0] cas_n,
  output logic [DW-1:0]    dq_out,
  output logic [DW-1:0]    rd_word
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic              cas_n_q;
    logic [LANE_W-1:0] out_q;
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (rst)           cas_n_q <= 1'b1;
      else if (cas_fall) cas_n_q <= 1'b0;
      else if (cas_rise) cas_n_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (rst)          out_q <= '0;
      else if (wr_load) out_q <= wr_word[g*LANE_W +: LANE_W];
    end

    // Capture on the rising strobe edge: EDO keeps the word on the bus.
    always_ff @(posedge clk) begin
      if (rst)      rd_q <= '0;
      else if (cap) rd_q <= dq_in[g*LANE_W +: LANE_W];
    end

    assign cas_n[g]                    = cas_n_q;
    assign dq_out[g*LANE_W +: LANE_W]  = out_q;
    assign rd_word[g*LANE_W +: LANE_W] = rd_q;
  end
endmodule

// File: rtl/edo_page_seq.sv
module edo_page_seq
  import edo_seq_pkg::*;
#(
  parameter int          ROW_W       = 10,
  parameter int          COL_W       = 10,
  parameter int          LANES       = 4,
  parameter int          LANE_W      = 9,
  parameter int unsigned CLK_NS      = 10,
  parameter int unsigned TRP_NS      = 30,
  parameter int unsigned TRCD_NS     = 18,
  parameter int unsigned TCP_NS      = 8,
  parameter int unsigned TCAS_NS     = 8,
  parameter int unsigned TCAC_NS     = 13,
  parameter int unsigned TRAS_MAX_NS = 100000
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_we,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [LANES*LANE_W-1:0] req_wdata,
  output logic                   rd_valid,
  output logic [LANES*LANE_W-1:0] rd_data,
  output logic [((ROW_W>COL_W)?ROW_W:COL_W)-1:0] dram_addr,
  output logic [1:0]             dram_ras_n,
  output logic [LANES-1:0]       dram_cas_n,
  output logic                   dram_we_n,
  output logic [LANES*LANE_W-1:0] dram_dq_out,
  output logic                   dram_dq_oe,
  input  logic [LANES*LANE_W-1:0] dram_dq_in
);
  localparam int          AW           = ROW_W + COL_W;
  localparam int          DW           = LANES * LANE_W;
  localparam int          BUS_W        = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int unsigned TRP_CYC      = ns_to_cyc(TRP_NS, CLK_NS);
  localparam int unsigned TRCD_CYC     = ns_to_cyc(TRCD_NS, CLK_NS);
  localparam int unsigned TCP_CYC      = ns_to_cyc(TCP_NS, CLK_NS);
  localparam int unsigned TCASL_CYC    = ns_to_cyc(umax(TCAS_NS, TCAC_NS), CLK_NS);
  localparam int unsigned TRAS_MAX_CYC = TRAS_MAX_NS / CLK_NS;
  localparam int unsigned GUARD_CYC    = TRCD_CYC + TCASL_CYC + TCP_CYC + 4;
  localparam int unsigned CLOSE_AT     = TRAS_MAX_CYC - GUARD_CYC;
  localparam int unsigned TMR_MAX      = umax(umax(TRP_CYC, TRCD_CYC), umax(TCP_CYC, TCASL_CYC));
  localparam int          TMR_W        = $clog2(TMR_MAX + 1);
  localparam int          AGE_W        = $clog2(TRAS_MAX_CYC + 1) + 1;

  seq_state_t       st;
  logic             ras_n_q, we_n_q, oe_q, rd_valid_q, pend_q, pend_we;
  logic [AW-1:0]    pend_addr;
  logic [DW-1:0]    pend_data;
  logic [BUS_W-1:0] addr_q;

  logic             tmr_load, tmr_done;
  logic [TMR_W-1:0] tmr_val;
  logic             hit, expired, accept, close_row;
  logic             cas_fall, cas_rise, cap, wr_load;
  logic [DW-1:0]    wr_word;
  logic [AGE_W-1:0] age;

  wire [ROW_W-1:0] req_row  = req_addr[AW-1:COL_W];
  wire [COL_W-1:0] req_col  = req_addr[COL_W-1:0];
  wire [ROW_W-1:0] pend_row = pend_addr[AW-1:COL_W];
  wire [COL_W-1:0] pend_col = pend_addr[COL_W-1:0];

  assign req_ready = tmr_done && ((st == S_IDLE) || ((st == S_OPEN) && !expired));
  assign accept    = req_valid && req_ready;
  assign close_row = (st == S_OPEN) && (expired || (accept && !hit));

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (st)
      S_ROWSET: begin tmr_load = 1'b1; tmr_val = TMR_W'(TRCD_CYC - 1); end
      S_COLSET: begin tmr_load = 1'b1; tmr_val = TMR_W'(TCASL_CYC - 1); end
      S_CASLOW: if (tmr_done) begin tmr_load = 1'b1; tmr_val = TMR_W'(TCP_CYC - 1); end
      S_OPEN:   if (close_row) begin tmr_load = 1'b1; tmr_val = TMR_W'(TRP_CYC - 1); end
      default: ;
    endcase
  end

  assign cas_fall = (st == S_COLSET);
  assign cas_rise = (st == S_CASLOW) && tmr_done;
  assign cap      = cas_rise && !pend_we;
  assign wr_load  = ((st == S_RCD) && tmr_done && pend_we) ||
                    ((st == S_OPEN) && accept && hit && req_we);
  assign wr_word  = (st == S_OPEN) ? req_wdata : pend_data;

  edo_delay_cnt #(.W(TMR_W)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .val(tmr_val), .done(tmr_done)
  );

  edo_row_tracker #(
    .ROW_W(ROW_W), .TRAS_MAX_CYC(TRAS_MAX_CYC), .CLOSE_AT(CLOSE_AT), .AGE_W(AGE_W)
  ) u_rows (
    .clk(clk), .rst(rst), .ras_low(!ras_n_q), .open_set(st == S_ROWSET),
    .close_set(close_row), .open_row(pend_row), .req_row(req_row),
    .hit(hit), .expired(expired), .age(age)
  );

  edo_lane_bank #(.LANES(LANES), .LANE_W(LANE_W)) u_lanes (
    .clk(clk), .rst(rst), .cas_fall(cas_fall), .cas_rise(cas_rise),
    .wr_load(wr_load), .wr_word(wr_word), .cap(cap), .dq_in(dram_dq_in),
    .cas_n(dram_cas_n), .dq_out(dram_dq_out), .rd_word(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      ras_n_q    <= 1'b1;
      we_n_q     <= 1'b1;
      oe_q       <= 1'b0;
      rd_valid_q <= 1'b0;
      pend_q     <= 1'b0;
      pend_we    <= 1'b0;
      pend_addr  <= '0;
      pend_data  <= '0;
      addr_q     <= '0;
    end else begin
      rd_valid_q <= cap;
      if (accept) begin
        pend_we   <= req_we;
        pend_addr <= req_addr;
        pend_data <= req_wdata;
      end
      unique case (st)
        S_IDLE: if (accept) begin
          addr_q <= BUS_W'(req_row);
          st     <= S_ROWSET;
        end
        S_ROWSET: begin
          ras_n_q <= 1'b0;
          st      <= S_RCD;
        end
        S_RCD: if (tmr_done) begin
          addr_q <= BUS_W'(pend_col);
          we_n_q <= !pend_we;
          oe_q   <= pend_we;
          st     <= S_COLSET;
        end
        S_COLSET: st <= S_CASLOW;
        S_CASLOW: if (tmr_done) begin
          we_n_q <= 1'b1;
          oe_q   <= 1'b0;
          st     <= S_OPEN;
        end
        S_OPEN: begin
          if (close_row) begin
            ras_n_q <= 1'b1;
            pend_q  <= !expired;
            st      <= S_PRECH;
          end else if (accept) begin
            addr_q <= BUS_W'(req_col);
            we_n_q <= !req_we;
            oe_q   <= req_we;
            st     <= S_COLSET;
          end
        end
        S_PRECH: if (tmr_done) begin
          pend_q <= 1'b0;
          if (pend_q) begin
            addr_q <= BUS_W'(pend_row);
            st     <= S_ROWSET;
          end else begin
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign dram_ras_n = {2{ras_n_q}};
  assign dram_we_n  = we_n_q;
  assign dram_dq_oe = oe_q;
  assign rd_valid   = rd_valid_q;
  assign dram_addr  = addr_q;

  // Cycles the row strobes have been high, for the precharge property.
  logic [TMR_W+1:0] ras_hi_cnt;
  always_ff @(posedge clk) begin
    if (rst)                      ras_hi_cnt <= '1;
    else if (ras_n_q == 1'b0)     ras_hi_cnt <= '0;
    else if (ras_hi_cnt != '1)    ras_hi_cnt <= ras_hi_cnt + 1'b1;
  end

  assert_cas_inside_ras_R4: assert property (@(posedge clk) disable iff (rst)
    (dram_cas_n != '1) |-> (dram_ras_n == 2'b00));

  assert_lanes_lockstep_R4: assert property (@(posedge clk) disable iff (rst)
    (dram_cas_n == '0) || (dram_cas_n == '1));

  assert_rcd_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_cas_n[0]) |-> (age >= AGE_W'(TRCD_CYC)));

  assert_precharge_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n_q) |-> ($past(ras_hi_cnt) >= (TMR_W+2)'(TRP_CYC)));

  assert_we_hold_R3: assert property (@(posedge clk) disable iff (rst)
    ((dram_cas_n[0] == 1'b0) && $past(dram_cas_n[0] == 1'b0)) |-> $stable(dram_we_n));

  assert_oe_only_write_R3: assert property (@(posedge clk) disable iff (rst)
    dram_dq_oe |-> !dram_we_n);

  assert_single_accept_R11: assert property (@(posedge clk) disable iff (rst)
    accept |=> !req_ready);

  assert_valid_after_rise_R2: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $rose(dram_cas_n[0]));
endmodule

// File: tb/sim_edo_page_seq.sv
module sim_edo_page_seq;
  localparam int ROW_W = 3, COL_W = 3, AW = 6, LANES = 4, LANE_W = 9, DW = 36;
  localparam int NW = 64;
  localparam int CLK_NS = 10;
  localparam int TRAS_MAX_NS = 2000;
  // Bench-side cycle minimums from the requirement numbers, rounded up.
  localparam int TRP_C  = (30 + CLK_NS - 1) / CLK_NS;
  localparam int TRCD_C = (18 + CLK_NS - 1) / CLK_NS;
  localparam int TCP_C  = (8 + CLK_NS - 1) / CLK_NS;
  localparam int TCASL_C = (13 + CLK_NS - 1) / CLK_NS;
  localparam int TRAS_C = TRAS_MAX_NS / CLK_NS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rd_valid, dram_we_n, dram_dq_oe;
  logic [DW-1:0] rd_data, dram_dq_out;
  logic [DW-1:0] dram_dq_in = '0;
  logic [2:0] dram_addr;
  logic [1:0] dram_ras_n;
  logic [LANES-1:0] dram_cas_n;

  always #5 clk = ~clk;

  edo_page_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .LANES(LANES), .LANE_W(LANE_W),
    .CLK_NS(CLK_NS), .TRAS_MAX_NS(TRAS_MAX_NS)
  ) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
  );

  int total = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a);
    logic [DW-1:0] v;
    v = DW'(a + 1) * 36'h0_9E37_79B1;
    return v ^ 36'hF_0F0F_0F0F;
  endfunction

  // Bench expectations
  logic [DW-1:0] golden [NW];
  int exp_q [256];
  int exp_wr = 0, exp_rd = 0;
  int cur_addr = 0;

  // Module model and pin monitors
  logic [DW-1:0] mem [NW];
  logic [ROW_W-1:0] m_row;
  int idx;
  logic prev_ras = 1'b1, prev_cas = 1'b1, we_at_fall = 1'b1;
  int ras_hi = 1000, ras_lo = 0, cas_hi = 1000, cas_lo = 0, since_ras = 0, max_lo = 0;
  int n_act = 0;
  int bad_addr = 0, bad_we = 0, bad_lane = 0, bad_rp = 0, bad_rcd = 0, bad_cas = 0, bad_ready = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (!(dram_ras_n == 2'b00 || dram_ras_n == 2'b11)) bad_lane++;
      if (!(dram_cas_n == '0 || dram_cas_n == '1)) bad_lane++;
      if (dram_cas_n != '1 && dram_ras_n != 2'b00) bad_lane++;
      if (dram_ras_n[0]) ras_hi++; else begin ras_lo++; since_ras++; end
      if (dram_cas_n[0]) cas_hi++; else cas_lo++;
      if (prev_ras && !dram_ras_n[0]) begin
        if (ras_hi - 1 < TRP_C) bad_rp++;
        m_row = dram_addr;
        if (dram_addr != 3'(cur_addr >> COL_W)) bad_addr++;
        n_act++; ras_lo = 1; since_ras = 0;
      end
      if (!prev_ras && dram_ras_n[0]) begin
        ras_hi = 1;
        if (dram_cas_n[0]) dram_dq_in = '0;
      end
      if (ras_lo > max_lo) max_lo = ras_lo;
      if (prev_cas && !dram_cas_n[0]) begin
        if (since_ras < TRCD_C) bad_rcd++;
        if (cas_hi - 1 < TCP_C) bad_cas++;
        if (dram_addr != 3'(cur_addr % (1 << COL_W))) bad_addr++;
        idx = {m_row, dram_addr};
        we_at_fall = dram_we_n;
        cas_lo = 1;
        if (!dram_we_n) begin
          if (!dram_dq_oe) bad_we++;
          for (int l = 0; l < LANES; l++)
            if (!dram_cas_n[l]) mem[idx][l*LANE_W +: LANE_W] = dram_dq_out[l*LANE_W +: LANE_W];
        end else begin
          if (dram_dq_oe) bad_we++;
          dram_dq_in = mem[idx];
        end
      end
      if (!dram_cas_n[0] && dram_we_n != we_at_fall) bad_we++;
      if (!prev_cas && dram_cas_n[0]) begin
        if (cas_lo < TCASL_C) bad_cas++;
        cas_hi = 1;
      end
      if (rd_valid) begin
        if (exp_rd < exp_wr) begin
          chk(rd_data == golden[exp_q[exp_rd]], "R2 read word", rd_data, golden[exp_q[exp_rd]]);
          exp_rd++;
        end else chk(1'b0, "R2 unexpected rd_valid", DW'(1), DW'(0));
      end
      prev_ras = dram_ras_n[0];
      prev_cas = dram_cas_n[0];
    end
  end

  task automatic do_req(input logic we, input int a);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = AW'(a); req_wdata = pat(a);
    cur_addr = a;
    if (we) golden[a] = pat(a);
    else begin exp_q[exp_wr % 256] = a; exp_wr++; end
    @(negedge clk);
    req_valid = 1'b0;
    if (req_ready) bad_ready++;
  endtask

  task automatic drain();
    repeat (20) @(negedge clk);
  endtask

  int act0;

  initial begin
    for (int i = 0; i < NW; i++) begin mem[i] = '0; golden[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(dram_ras_n == 2'b11, "R10 ras after reset", DW'(dram_ras_n), DW'(3));
    chk(dram_cas_n == '1, "R10 cas after reset", DW'(dram_cas_n), DW'(15));
    chk(dram_we_n == 1'b1, "R10 we after reset", DW'(dram_we_n), DW'(1));
    chk(dram_dq_oe == 1'b0 && rd_valid == 1'b0, "R10 oe/valid after reset",
        DW'({dram_dq_oe, rd_valid}), DW'(0));
    chk(req_ready == 1'b1, "R10 ready after reset", DW'(req_ready), DW'(1));

    // R8: sequential writes open each row once
    act0 = n_act;
    for (int a = 0; a < NW; a++) do_req(1'b1, a);
    drain();
    chk(n_act - act0 == 8, "R8 activations seq write", DW'(n_act - act0), DW'(8));

    // R2/R8: sequential read-back
    act0 = n_act;
    for (int a = 0; a < NW; a++) do_req(1'b0, a);
    drain();
    chk(n_act - act0 == 8, "R8 activations seq read", DW'(n_act - act0), DW'(8));

    // R8: stride 9 changes row every access
    act0 = n_act;
    for (int i = 0; i < NW; i++) do_req(1'b0, (i * 9) % NW);
    drain();
    chk(n_act - act0 == NW, "R8 activations stride read", DW'(n_act - act0), DW'(NW));

    // R3: overwrite a row in reverse column order, then read back interleaved
    for (int c = 7; c >= 0; c--) begin
      do_req(1'b1, 40 + c);
      golden[40 + c] = pat(40 + c);
    end
    for (int c = 0; c < 8; c++) do_req(1'b0, 40 + (c ^ 5));
    drain();

    // R9: an idle open row is closed on its own
    do_req(1'b0, 17);
    repeat (TRAS_C + 50) @(negedge clk);
    chk(dram_ras_n == 2'b11, "R9 idle row closed", DW'(dram_ras_n), DW'(3));
    do_req(1'b0, 18);
    drain();

    chk(exp_rd == exp_wr, "R2 read count", DW'(exp_rd), DW'(exp_wr));
    chk(bad_addr == 0, "R1 address mux", DW'(bad_addr), DW'(0));
    chk(bad_we == 0, "R3 write enable/oe", DW'(bad_we), DW'(0));
    chk(bad_lane == 0, "R4 strobe lanes", DW'(bad_lane), DW'(0));
    chk(bad_rp == 0, "R5 precharge", DW'(bad_rp), DW'(0));
    chk(bad_rcd == 0, "R6 row to column", DW'(bad_rcd), DW'(0));
    chk(bad_cas == 0, "R7 column strobe widths", DW'(bad_cas), DW'(0));
    chk(max_lo <= TRAS_C, "R9 max row-low", DW'(max_lo), DW'(TRAS_C));
    chk(bad_ready == 0, "R11 ready after accept", DW'(bad_ready), DW'(0));
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R11 watchdog hang", DW'(0), DW'(1));
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule